// File: doc/BRIEF.md
# Sticky Clear-on-Read Audio Event Interrupt Controller

This block gathers five event sources of a two-channel audio datapath into sticky status bits and a shared active-low interrupt line. Two sources come from built-in silence detectors, one per audio channel. Each detector watches its channel for a long unbroken run of samples that are all zeros or all ones. The other three sources arrive as single-cycle or level inputs: a clock fault on serial port 1, a clock fault on serial port 2, and positive full-scale clipping of the ADC. Clock-loss detection and clock-ratio measurement happen upstream of this block.

Each source has a mask bit and a 2-bit trigger mode. An unmasked source whose trigger condition holds sets its status bit. The bit stays set until the host reads the status register, and that read clears every bit at once. A host sets the masks and modes through one configuration register. It reads the status register, and the event that caused an interrupt can be found from it after the fact.

Top module: `audio_irq_ctrl`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1, every mode field is 00, and `intN` is 1.
- R2: Each channel has its own detector. The left detector drives status bit 0 and the right detector drives bit 1. A detector raises its event one cycle after it accepts the RUN_LEN-th consecutive valid sample that is all zeros, or the RUN_LEN-th that is all ones. Samples are accepted only while `sampleValid` is 1.
- R3: A run restarts when a sample is neither all zeros nor all ones. A run also restarts when the sample kind switches between all zeros and all ones; the switching sample counts as the first of the new run. Each run raises the event only once, even if the run continues past RUN_LEN samples.
- R4: `sp1ClkErr` feeds status bit 2, `sp2ClkErr` feeds bit 3, and `adcClipPos` feeds bit 4.
- R5: The mode field of source i sits in config bits [6+2i:5+2i]. The encodings are: 00 sets the bit on a rising edge of the event, 01 on a falling edge, and 10 in every cycle the event is high. Code 11 behaves as 00.
- R6: The mask bit of source i is config bit i. While it is 1, that source neither sets its status bit nor pulls `intN` low.
- R7: A status bit stays set until a read of address 0. That read returns the status in bits [4:0] and clears all status bits.
- R8: Writes to address 0 change nothing. A write to address 1 replaces the whole configuration word, and reading address 1 returns it.
- R9: If a trigger occurs in the same cycle as a status read, the read returns the old value and the new bit is set right after the clear.
- R10: `intN` is a registered output. It goes low one cycle after any unmasked status bit is pending. It stays low for one cycle after the read that clears the last pending bit, then returns to 1.
- R11: Read data appears on `regRdData` in the cycle after `regRdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Both channel samples are valid this cycle |
| sampleL | input | SAMPLE_W | Left channel sample |
| sampleR | input | SAMPLE_W | Right channel sample |
| sp1ClkErr | input | 1 | Clock fault indication, serial port 1 |
| sp2ClkErr | input | 1 | Clock fault indication, serial port 2 |
| adcClipPos | input | 1 | ADC data clipped to positive full scale |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 = status, 1 = configuration |
| regWrData | input | 15 | Write data: [4:0] masks, [14:5] modes |
| regRdData | output | 15 | Registered read data |
| intN | output | 1 | Active-low interrupt |

## Verification
A status read can collide with a new trigger, and the clearing read of one bit can meet the setting of another. The bench issues a status read in the same cycle as a serial-port fault pulse. It expects that read to return the prior value and the next read to show the fault bit. A sweep over every source, every mode code and both mask states checks both the status word and `intN` against values worked out from the source index. Separate run-length sequences on each channel check the detector restart rules and the single firing per run.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int SRC_N  = 5;
  localparam int CFG_W  = 3 * SRC_N;
  localparam int CH_N   = 2;

  typedef enum logic [1:0] {
    MODE_RISE  = 2'b00,
    MODE_FALL  = 2'b01,
    MODE_LEVEL = 2'b10,
    MODE_RSVD  = 2'b11
  } irqMode_e;

  typedef enum logic [1:0] {
    RUN_NONE = 2'b00,
    RUN_ZERO = 2'b01,
    RUN_ONES = 2'b10
  } runKind_e;

  typedef struct packed {
    logic stsClr;
  } ctlStrobe_t;
endpackage

// File: rtl/audio_mute_detect.sv
module audio_mute_detect
  import audio_irq_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 4096
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                hit
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  runKind_e         kind, kindNow;
  logic [CNT_W-1:0] runCnt, cntNext;
  logic             saturated;

  always_comb begin
    kindNow = RUN_NONE;
    if (sample == '0)      kindNow = RUN_ZERO;
    else if (&sample)      kindNow = RUN_ONES;
    saturated = (kindNow == kind) && (runCnt == CNT_MAX);
    if (kindNow == RUN_NONE)  cntNext = '0;
    else if (kindNow != kind) cntNext = CNT_W'(1);
    else if (saturated)       cntNext = runCnt;
    else                      cntNext = runCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kind   <= RUN_NONE;
      runCnt <= '0;
      hit    <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (valid) begin
        kind   <= kindNow;
        runCnt <= cntNext;
        hit    <= (cntNext == CNT_MAX) && !saturated;
      end
    end
  end
endmodule

// File: rtl/audio_irq_ctl.sv
module audio_irq_ctl
  import audio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic             regAddr,
  input  logic [CFG_W-1:0] regWrData,
  input  logic [SRC_N-1:0] status,
  output logic [CFG_W-1:0] regRdData,
  output ctlStrobe_t       strobe,
  output logic [SRC_N-1:0] mask,
  output logic [SRC_N-1:0][1:0] mode
);
  localparam logic ADDR_STS = 1'b0;
  localparam logic ADDR_CFG = 1'b1;
  localparam logic [CFG_W-1:0] CFG_RST = {{(2*SRC_N){1'b0}}, {SRC_N{1'b1}}};

  logic [CFG_W-1:0] cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= CFG_RST;
      regRdData <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_CFG) cfgReg <= regWrData;
      if (regRdEn)
        regRdData <= (regAddr == ADDR_CFG) ? cfgReg : CFG_W'(status);
    end
  end

  always_comb begin
    strobe.stsClr = regRdEn && (regAddr == ADDR_STS);
    mask          = cfgReg[SRC_N-1:0];
    mode          = cfgReg[CFG_W-1:SRC_N];
  end
endmodule

// File: rtl/audio_irq_dp.sv
module audio_irq_dp
  import audio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] evIn,
  input  logic [SRC_N-1:0] mask,
  input  logic [SRC_N-1:0][1:0] mode,
  input  ctlStrobe_t       strobe,
  output logic [SRC_N-1:0] status,
  output logic [SRC_N-1:0] setVec,
  output logic             intN
);
  logic [SRC_N-1:0] evPrev, trig;

  always_comb begin
    for (int i = 0; i < SRC_N; i++) begin
      case (irqMode_e'(mode[i]))
        MODE_FALL:  trig[i] = !evIn[i] && evPrev[i];
        MODE_LEVEL: trig[i] = evIn[i];
        default:    trig[i] = evIn[i] && !evPrev[i];
      endcase
    end
    setVec = trig & ~mask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evPrev <= '0;
      status <= '0;
      intN   <= 1'b1;
    end else begin
      evPrev <= evIn;
      status <= (strobe.stsClr ? '0 : status) | setVec;
      intN   <= ~|(status & ~mask);
    end
  end
endmodule

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
  import audio_irq_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 4096
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleL,
  input  logic [SAMPLE_W-1:0] sampleR,
  input  logic                sp1ClkErr,
  input  logic                sp2ClkErr,
  input  logic                adcClipPos,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic                regAddr,
  input  logic [14:0]         regWrData,
  output logic [14:0]         regRdData,
  output logic                intN
);
  logic [CH_N-1:0][SAMPLE_W-1:0] chSample;
  logic [CH_N-1:0]               muteHit;
  logic [SRC_N-1:0]              evIn, status, mask, setVec;
  logic [SRC_N-1:0][1:0]         mode;
  ctlStrobe_t                    strobe;

  assign chSample = {sampleR, sampleL};
  assign evIn     = {adcClipPos, sp2ClkErr, sp1ClkErr, muteHit};

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_mute
    audio_mute_detect #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_det (
      .clk(clk), .rstN(rstN), .valid(sampleValid),
      .sample(chSample[ch]), .hit(muteHit[ch])
    );
  end

  audio_irq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .status(status),
    .regRdData(regRdData), .strobe(strobe), .mask(mask), .mode(mode)
  );

  audio_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .evIn(evIn), .mask(mask), .mode(mode),
    .strobe(strobe), .status(status), .setVec(setVec), .intN(intN)
  );
endmodule

// File: rtl/audio_irq_check.sv
module audio_irq_check
  import audio_irq_pkg::*;
#(
  parameter int RUN_LEN = 4096
) (
  input logic             clk,
  input logic             rstN,
  input logic [SRC_N-1:0] status,
  input logic [SRC_N-1:0] mask,
  input logic [SRC_N-1:0] setVec,
  input logic             stsClr,
  input logic             intN,
  input logic [CH_N-1:0]  muteHit
);
  // R6: a newly set bit never comes from a masked source
  a_r6_masked_no_set: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~$past(status) & $past(mask)) == '0));

  // R7: a bit can only drop after a status read
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(status) & ~status)) |-> $past(stsClr));

  // R9: after a clearing read only same-cycle triggers remain
  a_r9_clear_keeps_new: assert property (@(posedge clk) disable iff (!rstN)
    stsClr |=> ((status & ~$past(setVec)) == '0));

  // R10: pending unmasked bit pulls intN low next cycle
  a_r10_int_low: assert property (@(posedge clk) disable iff (!rstN)
    (|(status & ~mask)) |=> !intN);

  // R10: nothing pending releases intN next cycle
  a_r10_int_high: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~mask) == '0) |=> intN);

  // R3: one event per run, never on back-to-back cycles
  a_r3_single_hit_l: assert property (@(posedge clk) disable iff (!rstN)
    (muteHit[0] && RUN_LEN > 1) |=> !muteHit[0]);
  a_r3_single_hit_r: assert property (@(posedge clk) disable iff (!rstN)
    (muteHit[1] && RUN_LEN > 1) |=> !muteHit[1]);
endmodule

bind audio_irq_ctrl audio_irq_check #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .status(status), .mask(mask), .setVec(setVec),
  .stsClr(strobe.stsClr), .intN(intN), .muteHit(muteHit)
);

// File: tb/tb_audio_irq_ctrl.sv
module tb_audio_irq_ctrl;
  localparam int SW  = 4;
  localparam int RL  = 8;
  localparam logic [SW-1:0] MIXED = 4'h5;

  logic clk = 1'b0, rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [SW-1:0] sampleL = MIXED, sampleR = MIXED;
  logic sp1ClkErr = 1'b0, sp2ClkErr = 1'b0, adcClipPos = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, regAddr = 1'b0;
  logic [14:0] regWrData = '0;
  logic [14:0] regRdData;
  logic intN;
  int checks = 0, errors = 0;

  audio_irq_ctrl #(.SAMPLE_W(SW), .RUN_LEN(RL)) dut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rdReg(input logic a, output logic [14:0] v);
    regRdEn = 1'b1; regAddr = a;
    tick(1);
    regRdEn = 1'b0;
    v = regRdData;
  endtask

  task automatic wrCfg(input logic [14:0] d);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic feed(input int ch, input logic [SW-1:0] s, input int n);
    sampleValid = 1'b1;
    for (int i = 0; i < n; i++) begin
      sampleL = (ch == 0) ? s : MIXED;
      sampleR = (ch == 1) ? s : MIXED;
      tick(1);
    end
    sampleValid = 1'b0;
  endtask

  task automatic pulse(input int src);
    case (src)
      2: sp1ClkErr = 1'b1;
      3: sp2ClkErr = 1'b1;
      default: adcClipPos = 1'b1;
    endcase
    tick(1);
    sp1ClkErr = 1'b0; sp2ClkErr = 1'b0; adcClipPos = 1'b0;
  endtask

  function automatic logic [14:0] cfgWord(input logic [1:0] m, input logic [4:0] msk);
    return {m, m, m, m, m, msk};
  endfunction

  logic [14:0] v;

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    check("R1 intN", intN, 1);
    rdReg(1'b1, v); check("R1 cfg", v, 15'h001F);
    rdReg(1'b0, v); check("R1 status", v, 0);

    // R8: writes to status are ignored; cfg readback
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = 15'h7FFF; tick(1); regWrEn = 1'b0;
    rdReg(1'b0, v); check("R8 status write", v, 0);
    rdReg(1'b1, v); check("R8 cfg untouched", v, 15'h001F);
    wrCfg(15'h5A6C);
    rdReg(1'b1, v); check("R8 cfg readback", v, 15'h5A6C);
    check("R11 read latency", regRdData, 15'h5A6C);

    // sweep sources x modes x mask (R2 R4 R5 R6)
    for (int src = 0; src < 5; src++)
      for (int m = 0; m < 4; m++)
        for (int mk = 0; mk < 2; mk++) begin
          wrCfg(cfgWord(2'(m), mk ? 5'h1F : ~(5'(1) << src)));
          rdReg(1'b0, v);
          tick(2);
          rdReg(1'b0, v);
          if (src < 2) begin
            feed(src, MIXED, 1);
            feed(src, (m[0] ? 4'hF : 4'h0), RL);
          end else pulse(src);
          tick(4);
          check(mk ? "R6 masked intN" : "R10 intN sweep", intN, mk ? 1 : 0);
          rdReg(1'b0, v);
          check(mk ? "R6 masked status" : (src < 2 ? "R2 mute status" : "R4 R5 status"),
                v, mk ? 0 : (32'h1 << src));
        end

    // R3 restart rules, rising mode, all unmasked
    wrCfg(cfgWord(2'b00, 5'h00));
    feed(0, MIXED, 1);
    feed(0, 4'h0, RL - 1); feed(0, MIXED, 1); feed(0, 4'h0, RL - 1);
    tick(3); rdReg(1'b0, v); check("R3 break restarts", v, 0);
    feed(0, 4'h0, 1);
    tick(3); rdReg(1'b0, v); check("R3 full run fires", v, 1);
    feed(1, 4'h0, 4); feed(1, 4'hF, RL - 1);
    tick(3); rdReg(1'b0, v); check("R3 kind switch restarts", v, 0);
    feed(1, 4'hF, 1);
    tick(3); rdReg(1'b0, v); check("R2 right ones run", v, 2);
    feed(0, MIXED, 1); feed(0, 4'h0, 2 * RL + 4);
    tick(3); rdReg(1'b0, v); check("R3 long run fires", v, 1);
    feed(0, 4'h0, RL + 2);
    tick(3); rdReg(1'b0, v); check("R3 once per run", v, 0);
    // R2: invalid samples are not counted
    feed(0, MIXED, 1); feed(0, 4'h0, RL - 1);
    sampleL = 4'h0; tick(4);
    rdReg(1'b0, v); check("R2 valid gating", v, 0);

    // R5 level vs edge on the clip input
    wrCfg(cfgWord(2'b10, 5'h00));
    adcClipPos = 1'b1; tick(3);
    rdReg(1'b0, v); check("R5 level set", v, 15'h10);
    tick(1);
    rdReg(1'b0, v); check("R5 level resets while high", v, 15'h10);
    wrCfg(cfgWord(2'b00, 5'h00));
    rdReg(1'b0, v); tick(1);
    rdReg(1'b0, v); check("R5 rise no refire while high", v, 0);
    wrCfg(cfgWord(2'b01, 5'h00));
    adcClipPos = 1'b0; tick(3);
    rdReg(1'b0, v); check("R5 falling edge", v, 15'h10);

    // R7 sticky across idle cycles
    wrCfg(cfgWord(2'b00, 5'h00));
    pulse(3); tick(10);
    rdReg(1'b0, v); check("R7 sticky", v, 15'h08);
    rdReg(1'b0, v); check("R7 cleared by read", v, 0);

    // R9 event in the read cycle
    regRdEn = 1'b1; regAddr = 1'b0; sp1ClkErr = 1'b1;
    tick(1);
    regRdEn = 1'b0; sp1ClkErr = 1'b0;
    check("R9 read sees old", regRdData, 0);
    tick(1);
    rdReg(1'b0, v); check("R9 event kept", v, 15'h04);

    // R10 intN timing
    tick(2);
    check("R10 idle high", intN, 1);
    pulse(3);
    check("R10 registered lag", intN, 1);
    tick(1);
    check("R10 low", intN, 0);
    rdReg(1'b0, v);
    check("R10 held after read", intN, 0);
    tick(1);
    check("R10 released", intN, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule